// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block sits between a simple word-request host port and a four-bank, 32-bit synchronous DRAM. Every accepted request is one 32-bit read or write. The block turns it into row-open, column and row-close commands on the memory's command strobes, bank pins, 11-bit address bus and four byte masks. On the first access to a bank, or on a change of row, it opens the row. An access to the row already open in that bank goes straight to the column command. Rows stay open between accesses, and column commands never request automatic precharge.

After reset the block waits for a power-up interval. It then closes all banks, issues two auto-refresh commands and loads the mode register, with burst length 1, sequential order and the CAS latency chosen by a configuration pin. From then on a free-running interval timer raises a refresh request. That request wins over new host traffic. It closes every bank and then issues one auto-refresh. Read data is taken from the data bus a programmed 2 or 3 cycles after the memory samples the read command. It is returned on a response strobe.

The host port uses valid/ready. The block takes a request on a cycle where both are high. Ready is high only while the sequencer is idle with no refresh due, so only one request is in flight at a time. The host may hold a request as long as it likes. The read response has no back-pressure: the host must take `rsp_data` in the one cycle that `rsp_valid` is high.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset the command bus carries only NOP for more than INIT_WAIT cycles. Then come, in order: precharge with A10=1, auto-refresh, auto-refresh, and mode load. The mode load has BA=0 and an address of all zeros except bits 6:4, which hold the CAS latency (2 or 3, taken from `cfg_cas3`). `req_ready` stays low until the mode load has been issued.
- R2: Commands are encoded as {cs_n,ras_n,cas_n,we_n}: MRS 0000, REF 0001, PRE 0010, ACT 0011, WR 0100, RD 0101, NOP 0111. Every non-command cycle, including reset, carries NOP.
- R3: `req_addr` is {bank[20:19], row[18:8], column[7:0]}. An access to a bank with no open row issues ACT with that bank and row, then the column command at least T_RCD cycles later, with no precharge.
- R4: An access to a bank whose open row differs issues a single-bank PRE (A10=0), then ACT at least T_RP cycles later. ACT is never issued to a bank with an open row.
- R5: An access to the row already open in its bank issues the column command with no ACT and no PRE.
- R6: A column command carries the request's bank and the column in A7:A0, with A10 (auto-precharge flag) and A9:A8 at 0. It is issued only to a bank whose open row is the requested row.
- R7: A write drives `mem_dq_out` with the write data and raises `mem_dq_oe` in the same cycle as WR, and only then. In that cycle `mem_dqm` = ~`req_wmask`, so a mask bit of 0 leaves that byte of memory untouched.
- R8: A read issues RD with `mem_dqm` = 0. `rsp_valid` is high for one cycle, CL+1 cycles after the memory samples RD. `rsp_data` is the word the memory returned.
- R9: Every REFI cycles after the mode load a refresh falls due. It is served before any new request: a precharge of all banks, then REF with every bank closed. Successive REFs are at most REFI plus one transaction apart.
- R10: A request is accepted only when `req_valid` and `req_ready` are both high. `req_ready` then drops until the sequencer is idle again.
- R11: ACT or REF comes at least T_RP cycles after a precharge of its bank. The next command after REF comes at least T_RFC cycles after it, and the next command after the mode load at least T_MRD cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cas3 | input | 1 | 1 selects CAS latency 3, 0 selects 2; sampled at the mode load |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 21 | {bank, row, column} word address |
| req_wdata | input | 32 | Write data |
| req_wmask | input | 4 | Byte-lane write enables, 1 = write lane |
| rsp_valid | output | 1 | Read data strobe, one cycle |
| rsp_data | output | 32 | Read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_ba | output | 2 | Bank address |
| mem_addr | output | 11 | Row / column / mode address |
| mem_dqm | output | 4 | Byte masks |
| mem_dq_out | output | 32 | Write data to memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 32 | Read data from memory |

## Verification
The bench sweeps all four banks over the lowest, the highest and a middle row and column, under both CAS latencies. In each sweep, same-row follow-ups, row changes and first touches of a bank follow one another. A design that mistook a hit for a miss would show extra ACT or PRE commands. One that skipped the close before a row change would activate an open bank, or write to the wrong row. Partial and all-zero byte masks catch a design that writes lanes it should leave alone. Reading at a capture point one cycle off returns the bus filler word instead of the stored data. Refresh falls due during the traffic, so a design that let requests starve refresh, or refreshed with banks open, breaks the interval bound or the bank-closed rule.

// File: rtl/sdram_seq_pkg.sv
`timescale 1ns/1ps
package sdram_seq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } mem_cmd_e;

  typedef enum logic [3:0] {
    ST_POWERUP, ST_IPRE, ST_IREF1, ST_IREF2, ST_IMRS,
    ST_IDLE, ST_PRE, ST_ACT, ST_COL, ST_RPRE, ST_RREF, ST_WAIT
  } seq_state_e;
endpackage

// File: rtl/sdram_refresh_timer.sv
`timescale 1ns/1ps
module sdram_refresh_timer #(
  parameter int REFI = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ack,
  output logic pending
);
  localparam int TW = $clog2(REFI + 1);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      if (ack) pending <= 1'b0;
      if (enable) begin
        if (cnt == TW'(REFI - 1)) begin
          cnt     <= '0;
          pending <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R9: the interval counter wraps inside one refresh period
  assert_refi_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < TW'(REFI));
  // R9: a due refresh is held until the sequencer serves it
  assert_pending_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !ack |=> pending);
endmodule

// File: rtl/sdram_row_tracker.sv
`timescale 1ns/1ps
module sdram_row_tracker #(
  parameter int BA_W  = 2,
  parameter int ROW_W = 11
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             act_en,
  input  logic [BA_W-1:0]                  act_bank,
  input  logic [ROW_W-1:0]                 act_row,
  input  logic                             pre_en,
  input  logic                             pre_all,
  input  logic [BA_W-1:0]                  pre_bank,
  output logic [(1<<BA_W)-1:0]             open_mask,
  output logic [(1<<BA_W)-1:0][ROW_W-1:0]  open_rows
);
  localparam int NBANK = 1 << BA_W;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic             is_open;
    logic [ROW_W-1:0] row_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        is_open <= 1'b0;
        row_r   <= '0;
      end else if (act_en && act_bank == BA_W'(b)) begin
        is_open <= 1'b1;
        row_r   <= act_row;
      end else if (pre_en && (pre_all || pre_bank == BA_W'(b))) begin
        is_open <= 1'b0;
      end
    end
    assign open_mask[b] = is_open;
    assign open_rows[b] = row_r;
  end

  // R4: a row is never opened in a bank that already has one open
  assert_act_closed_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_en |-> !open_mask[act_bank]);
endmodule

// File: rtl/sdram_rd_capture.sv
`timescale 1ns/1ps
module sdram_rd_capture #(
  parameter int DW     = 32,
  parameter int MAX_CL = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          cas3,
  input  logic [DW-1:0] dq_in,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  logic [MAX_CL:0] pipe;
  logic            tap;

  assign tap = cas3 ? pipe[MAX_CL] : pipe[MAX_CL-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe      <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      pipe      <= {pipe[MAX_CL-1:0], issue};
      rsp_valid <= tap;
      if (tap) rsp_data <= dq_in;
    end
  end

  // R8: each read yields a single-cycle response strobe
  assert_rsp_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/sdram_cmd_seq.sv
`timescale 1ns/1ps
module sdram_cmd_seq import sdram_seq_pkg::*; #(
  parameter int BA_W      = 2,
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8,
  parameter int DW        = 32,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 9,
  parameter int T_MRD     = 2,
  parameter int T_WR      = 2,
  parameter int REFI      = 1560,
  parameter int INIT_WAIT = 20000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_cas3,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic [BA_W+ROW_W+COL_W-1:0] req_addr,
  input  logic [DW-1:0]               req_wdata,
  input  logic [DW/8-1:0]             req_wmask,
  output logic                        rsp_valid,
  output logic [DW-1:0]               rsp_data,
  output logic                        mem_cs_n,
  output logic                        mem_ras_n,
  output logic                        mem_cas_n,
  output logic                        mem_we_n,
  output logic [BA_W-1:0]             mem_ba,
  output logic [ROW_W-1:0]            mem_addr,
  output logic [DW/8-1:0]             mem_dqm,
  output logic [DW-1:0]               mem_dq_out,
  output logic                        mem_dq_oe,
  input  logic [DW-1:0]               mem_dq_in
);
  // Timing parameters must be at least 2: a wait of K cycles gives a gap of K+2.
  localparam int NBANK = 1 << BA_W;
  localparam int MW    = DW / 8;
  localparam int CW    = ($clog2(INIT_WAIT + 1) > 6) ? $clog2(INIT_WAIT + 1) : 6;
  localparam logic [CW-1:0] K_RCD = CW'(T_RCD - 2);
  localparam logic [CW-1:0] K_RP  = CW'(T_RP - 2);
  localparam logic [CW-1:0] K_RFC = CW'(T_RFC - 2);
  localparam logic [CW-1:0] K_MRD = CW'(T_MRD - 2);
  localparam logic [CW-1:0] K_WR  = CW'(T_WR - 2);
  localparam logic [ROW_W-1:0] AP_BIT = ROW_W'(1) << 10;

  seq_state_e        state, ret;
  logic [CW-1:0]     cnt;
  mem_cmd_e          cmd_q;
  logic [BA_W-1:0]   ba_q;
  logic [ROW_W-1:0]  addr_q, mode_word;
  logic [MW-1:0]     dqm_q;
  logic [DW-1:0]     dq_q;
  logic              oe_q, cas3_q, run_q;
  logic              q_write;
  logic [BA_W-1:0]   q_bank;
  logic [ROW_W-1:0]  q_row;
  logic [COL_W-1:0]  q_col;
  logic [DW-1:0]     q_wdata;
  logic [MW-1:0]     q_wmask;
  logic [BA_W-1:0]   in_bank;
  logic [ROW_W-1:0]  in_row;
  logic [COL_W-1:0]  in_col;
  logic              in_open, in_hit, ref_pend;
  logic [NBANK-1:0]             open_mask;
  logic [NBANK-1:0][ROW_W-1:0]  open_rows;

  assign {in_bank, in_row, in_col} = req_addr;
  assign in_open   = open_mask[in_bank];
  assign in_hit    = in_open && (open_rows[in_bank] == in_row);
  assign req_ready = (state == ST_IDLE) && !ref_pend;

  always_comb begin
    mode_word      = '0;
    mode_word[6:4] = cfg_cas3 ? 3'd3 : 3'd2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_POWERUP;
      ret    <= ST_IDLE;
      cnt    <= CW'(INIT_WAIT);
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      dqm_q  <= '0;
      dq_q   <= '0;
      oe_q   <= 1'b0;
      cas3_q <= 1'b0;
      run_q  <= 1'b0;
      q_write <= 1'b0;
      q_bank  <= '0;
      q_row   <= '0;
      q_col   <= '0;
      q_wdata <= '0;
      q_wmask <= '0;
    end else begin
      cmd_q <= CMD_NOP;
      oe_q  <= 1'b0;
      dqm_q <= '0;
      unique case (state)
        ST_POWERUP: if (cnt == '0) state <= ST_IPRE; else cnt <= cnt - 1'b1;
        ST_IPRE, ST_RPRE: begin
          cmd_q <= CMD_PRE; addr_q <= AP_BIT; cnt <= K_RP; state <= ST_WAIT;
          ret   <= (state == ST_IPRE) ? ST_IREF1 : ST_RREF;
        end
        ST_IREF1, ST_IREF2, ST_RREF: begin
          cmd_q <= CMD_REF; cnt <= K_RFC; state <= ST_WAIT;
          ret   <= (state == ST_IREF1) ? ST_IREF2 : (state == ST_IREF2) ? ST_IMRS : ST_IDLE;
        end
        ST_IMRS: begin
          cmd_q <= CMD_MRS; ba_q <= '0; addr_q <= mode_word; cas3_q <= cfg_cas3;
          run_q <= 1'b1; cnt <= K_MRD; ret <= ST_IDLE; state <= ST_WAIT;
        end
        ST_IDLE: begin
          if (ref_pend) begin
            state <= ST_RPRE;
          end else if (req_valid) begin
            q_write <= req_write; q_bank <= in_bank; q_row <= in_row; q_col <= in_col;
            q_wdata <= req_wdata; q_wmask <= req_wmask;
            state   <= in_hit ? ST_COL : (in_open ? ST_PRE : ST_ACT);
          end
        end
        ST_PRE: begin
          cmd_q <= CMD_PRE; ba_q <= q_bank; addr_q <= '0;
          cnt <= K_RP; ret <= ST_ACT; state <= ST_WAIT;
        end
        ST_ACT: begin
          cmd_q <= CMD_ACT; ba_q <= q_bank; addr_q <= q_row;
          cnt <= K_RCD; ret <= ST_COL; state <= ST_WAIT;
        end
        ST_COL: begin
          cmd_q  <= q_write ? CMD_WR : CMD_RD;
          ba_q   <= q_bank;
          addr_q <= ROW_W'(q_col);
          if (q_write) begin
            oe_q <= 1'b1; dq_q <= q_wdata; dqm_q <= ~q_wmask; cnt <= K_WR;
          end else begin
            cnt <= cas3_q ? CW'(3) : CW'(2);
          end
          ret <= ST_IDLE; state <= ST_WAIT;
        end
        ST_WAIT: if (cnt == '0) state <= ret; else cnt <= cnt - 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd_q;
  assign mem_ba     = ba_q;
  assign mem_addr   = addr_q;
  assign mem_dqm    = dqm_q;
  assign mem_dq_out = dq_q;
  assign mem_dq_oe  = oe_q;

  sdram_refresh_timer #(.REFI(REFI)) u_refresh (
    .clk(clk), .rst_n(rst_n), .enable(run_q),
    .ack(state == ST_RREF), .pending(ref_pend)
  );

  sdram_row_tracker #(.BA_W(BA_W), .ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n),
    .act_en(state == ST_ACT), .act_bank(q_bank), .act_row(q_row),
    .pre_en(state == ST_PRE || state == ST_RPRE || state == ST_IPRE),
    .pre_all(state != ST_PRE), .pre_bank(q_bank),
    .open_mask(open_mask), .open_rows(open_rows)
  );

  sdram_rd_capture #(.DW(DW), .MAX_CL(3)) u_capture (
    .clk(clk), .rst_n(rst_n), .issue(state == ST_COL && !q_write),
    .cas3(cas3_q), .dq_in(mem_dq_in), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // R6: column commands only reach a bank holding an open row
  assert_col_open_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> open_mask[ba_q]);
  // R6: column commands never request auto-precharge
  assert_col_no_autopre_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> !mem_addr[10]);
  // R9: auto-refresh only with every bank closed
  assert_ref_all_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_REF) |-> (open_mask == '0));
  // R7: the data bus is driven only alongside a write command
  assert_oe_with_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (cmd_q == CMD_WR));
  // R10: after an accept, no second request is taken on the next cycle
  assert_one_in_flight_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/sim_sdram_cmd_seq.sv
`timescale 1ns/1ps
module sim_sdram_cmd_seq;
  localparam int T_RCD = 3, T_RP = 2, T_RFC = 6, T_MRD = 2, T_WR = 2;
  localparam int REFI = 300, INIT_WAIT = 40;
  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111;

  logic clk = 1'b0, rst_n = 1'b0, cfg_cas3 = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [20:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_wmask = '0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_data;
  logic mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe;
  logic [1:0] mem_ba;
  logic [10:0] mem_addr;
  logic [3:0] mem_dqm;
  logic [31:0] mem_dq_out, mem_dq_in;

  always #5 clk = ~clk;

  sdram_cmd_seq #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
                  .T_WR(T_WR), .REFI(REFI), .INIT_WAIT(INIT_WAIT)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_cas3(cfg_cas3),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_wmask(req_wmask),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_ba(mem_ba), .mem_addr(mem_addr), .mem_dqm(mem_dqm),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int n_tests = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- memory stub and bus monitor ----------------
  logic [31:0] smem [int];
  logic [31:0] model [int];
  logic [3:0]  rp_v;
  logic [31:0] rp_d [0:3];
  int  cyc, init_step, rd_cyc, last_ref, last_mrs, last_pre_any, last_refp;
  int  last_act [0:3];
  int  last_pre [0:3];
  int  mrow [0:3];
  bit  [3:0] mopen;
  int  act_cnt, pre_cnt, ref_cnt, col_cnt;
  int  exp_bank, exp_row, exp_col;
  logic [31:0] exp_data;
  logic [3:0]  exp_mask;
  logic [3:0]  cmd;

  assign mem_dq_in = cfg_cas3 ? (rp_v[2] ? rp_d[2] : 32'hDEADBEEF)
                              : (rp_v[1] ? rp_d[1] : 32'hDEADBEEF);

  always @(posedge clk) begin
    int key, cl;
    logic [31:0] w, rdv;
    cl  = cfg_cas3 ? 3 : 2;
    cmd = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
    rdv = 32'h0;
    if (!rst_n) begin
      cyc = 0; init_step = 0; rd_cyc = -1000; last_ref = -1000; last_mrs = -1000;
      last_pre_any = -1000; last_refp = 0; mopen = '0;
      for (int b = 0; b < 4; b++) begin last_act[b] = -1000; last_pre[b] = -1000; mrow[b] = 0; end
    end else begin
      cyc++;
      if (rsp_valid) chk(cyc - rd_cyc == cl + 1, "R8 response latency", 64'(cyc - rd_cyc), 64'(cl + 1));
      if (mem_dq_oe) chk(cmd == C_WR, "R7 bus driven only on write", 64'(cmd), 64'(C_WR));
      if (cmd != C_NOP) begin
        chk(cmd inside {C_MRS, C_REF, C_PRE, C_ACT, C_WR, C_RD}, "R2 legal command code", 64'(cmd), 64'(C_NOP));
        chk(cyc - last_ref >= T_RFC, "R11 refresh recovery", 64'(cyc - last_ref), 64'(T_RFC));
        chk(cyc - last_mrs >= T_MRD, "R11 mode load recovery", 64'(cyc - last_mrs), 64'(T_MRD));
      end
      if (init_step < 4 && cmd != C_NOP) begin
        case (init_step)
          0: begin
            chk(cmd == C_PRE && mem_addr[10], "R1 init precharge-all", 64'({cmd, mem_addr}), 64'({C_PRE, 11'h400}));
            chk(cyc > INIT_WAIT, "R1 power-up wait", 64'(cyc), 64'(INIT_WAIT + 1));
          end
          1, 2: chk(cmd == C_REF, "R1 init refresh", 64'(cmd), 64'(C_REF));
          default: chk(cmd == C_MRS && mem_ba == 2'd0 && mem_addr == 11'(cl << 4),
                       "R1 mode load word", 64'({cmd, mem_addr}), 64'({C_MRS, 11'(cl << 4)}));
        endcase
        init_step++;
      end else if (cmd == C_MRS) begin
        chk(1'b0, "R1 mode load outside init", 64'(cmd), 64'(C_NOP));
      end
      case (cmd)
        C_MRS: begin last_mrs = cyc; last_refp = cyc; end
        C_ACT: begin
          chk(!mopen[mem_ba], "R4 activate to closed bank", 64'(mopen), 64'(0));
          chk(cyc - last_pre[mem_ba] >= T_RP, "R11 precharge to activate", 64'(cyc - last_pre[mem_ba]), 64'(T_RP));
          mopen[mem_ba] = 1'b1; mrow[mem_ba] = int'(mem_addr); last_act[mem_ba] = cyc; act_cnt++;
        end
        C_PRE: begin
          if (mem_addr[10]) begin
            mopen = '0;
            for (int b = 0; b < 4; b++) last_pre[b] = cyc;
          end else begin
            mopen[mem_ba] = 1'b0; last_pre[mem_ba] = cyc; pre_cnt++;
          end
          last_pre_any = cyc;
        end
        C_REF: begin
          chk(mopen == '0, "R9 refresh with banks closed", 64'(mopen), 64'(0));
          chk(cyc - last_pre_any >= T_RP, "R11 precharge to refresh", 64'(cyc - last_pre_any), 64'(T_RP));
          if (init_step >= 4) begin
            chk(cyc - last_refp <= REFI + 24, "R9 refresh interval", 64'(cyc - last_refp), 64'(REFI + 24));
            last_refp = cyc; ref_cnt++;
          end
          last_ref = cyc;
        end
        C_WR, C_RD: begin
          chk(mopen[mem_ba], "R6 column to open bank", 64'(mopen), 64'(1 << mem_ba));
          chk(cyc - last_act[mem_ba] >= T_RCD, "R3 activate to column", 64'(cyc - last_act[mem_ba]), 64'(T_RCD));
          chk(mem_addr[10:8] == 3'b000, "R6 A10 auto-precharge and A9:A8 low", 64'(mem_addr[10:8]), 64'(0));
          chk(int'(mem_ba) == exp_bank && mrow[mem_ba] == exp_row && int'(mem_addr[7:0]) == exp_col,
              "R6 bank/row/column", 64'({mem_ba, 11'(mrow[mem_ba]), mem_addr[7:0]}),
              64'({2'(exp_bank), 11'(exp_row), 8'(exp_col)}));
          key = (int'(mem_ba) << 19) | (mrow[mem_ba] << 8) | int'(mem_addr[7:0]);
          if (cmd == C_WR) begin
            chk(mem_dq_oe && mem_dq_out == exp_data, "R7 write data driven", 64'({mem_dq_oe, mem_dq_out}), 64'({1'b1, exp_data}));
            chk(mem_dqm == ~exp_mask, "R7 byte masks", 64'(mem_dqm), 64'(~exp_mask));
            w = smem.exists(key) ? smem[key] : 32'h0;
            for (int l = 0; l < 4; l++) if (!mem_dqm[l]) w[l*8 +: 8] = mem_dq_out[l*8 +: 8];
            smem[key] = w;
          end else begin
            chk(mem_dqm == 4'h0, "R8 read masks clear", 64'(mem_dqm), 64'(0));
            rdv = smem.exists(key) ? smem[key] : 32'h0;
            rd_cyc = cyc;
          end
          col_cnt++;
        end
        default: ;
      endcase
    end
    rp_v    <= rst_n ? {rp_v[2:0], (cmd == C_RD)} : 4'h0;
    rp_d[0] <= rdv;
    for (int i = 1; i < 4; i++) rp_d[i] <= rp_d[i-1];
  end

  // ---------------- stimulus ----------------
  task automatic do_op(input bit wr, input int bank, input int row, input int col,
                       input logic [31:0] data, input logic [3:0] mask);
    int tmo, a0, p0, r0, c0, key;
    bit was_open, was_hit;
    logic [31:0] w;
    tmo = 0;
    @(negedge clk);
    while (!req_ready && tmo < 300) begin @(negedge clk); tmo++; end
    chk(tmo < 300, "R10 ready returns", 64'(tmo), 64'(0));
    was_open = mopen[bank];
    was_hit  = was_open && mrow[bank] == row;
    a0 = act_cnt; p0 = pre_cnt; r0 = ref_cnt; c0 = col_cnt;
    exp_bank = bank; exp_row = row; exp_col = col; exp_data = data; exp_mask = mask;
    req_valid = 1'b1; req_write = wr; req_addr = {2'(bank), 11'(row), 8'(col)};
    req_wdata = data; req_wmask = mask;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R10 ready drops after accept", 64'(req_ready), 64'(0));
    key = (bank << 19) | (row << 8) | col;
    tmo = 0;
    if (wr) begin
      while (col_cnt == c0 && tmo < 60) begin @(negedge clk); tmo++; end
      w = model.exists(key) ? model[key] : 32'h0;
      for (int l = 0; l < 4; l++) if (mask[l]) w[l*8 +: 8] = data[l*8 +: 8];
      model[key] = w;
    end else begin
      while (!rsp_valid && tmo < 60) begin @(negedge clk); tmo++; end
      w = model.exists(key) ? model[key] : 32'h0;
      chk(rsp_valid && rsp_data == w, "R8 read data", 64'({rsp_valid, rsp_data}), 64'({1'b1, w}));
    end
    chk(tmo < 60, "R3 column command issued", 64'(tmo), 64'(0));
    if (ref_cnt == r0) begin
      if (was_hit)
        chk(act_cnt == a0 && pre_cnt == p0, "R5 row hit without ACT/PRE", 64'({act_cnt - a0, pre_cnt - p0}), 64'(0));
      else if (was_open)
        chk(act_cnt == a0 + 1 && pre_cnt == p0 + 1, "R4 row conflict PRE then ACT",
            64'({act_cnt - a0, pre_cnt - p0}), 64'({32'd1, 32'd1}));
      else
        chk(act_cnt == a0 + 1 && pre_cnt == p0, "R3 closed bank ACT only",
            64'({act_cnt - a0, pre_cnt - p0}), 64'({32'd1, 32'd0}));
    end
  endtask

  initial begin
    int rows [3];
    int cols [3];
    logic [3:0] masks [4];
    rows = '{0, 2047, 5};
    cols = '{0, 255, 17};
    masks = '{4'h5, 4'hA, 4'h3, 4'h0};
    for (int cl3 = 0; cl3 < 2; cl3++) begin
      rst_n = 1'b0; cfg_cas3 = cl3[0];
      smem.delete(); model.delete();
      act_cnt = 0; pre_cnt = 0; ref_cnt = 0; col_cnt = 0;
      exp_bank = 0; exp_row = 0; exp_col = 0; exp_data = '0; exp_mask = '0;
      repeat (3) @(negedge clk);
      chk({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == C_NOP, "R2 NOP in reset",
          64'({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}), 64'(C_NOP));
      chk(!req_ready && !rsp_valid && !mem_dq_oe, "R10 reset outputs idle",
          64'({req_ready, rsp_valid, mem_dq_oe}), 64'(0));
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      chk(!req_ready, "R1 not ready during power-up", 64'(req_ready), 64'(0));
      begin
        int tmo = 0;
        while (!req_ready && tmo < 500) begin @(negedge clk); tmo++; end
      end
      chk(init_step == 4, "R1 init sequence complete before ready", 64'(init_step), 64'(4));
      // full-word writes over banks, rows, columns
      for (int b = 0; b < 4; b++)
        for (int r = 0; r < 3; r++)
          for (int c = 0; c < 3; c++)
            do_op(1'b1, b, rows[r], cols[c],
                  32'(b * 32'h01000193 + rows[r] * 32'h9E37 + cols[c] * 32'h101 + cl3 * 32'h5555), 4'hF);
      // partial writes, including an all-masked write
      for (int b = 0; b < 4; b++)
        for (int r = 0; r < 3; r++)
          for (int c = 0; c < 3; c++)
            do_op(1'b1, b, rows[r], cols[c],
                  ~32'(b * 32'h0BADF00D + rows[r] * 32'h77 + cols[c] * 32'h3C3), masks[(b * 9 + r * 3 + c) % 4]);
      // read everything back
      for (int b = 0; b < 4; b++)
        for (int r = 0; r < 3; r++)
          for (int c = 0; c < 3; c++)
            do_op(1'b0, b, rows[r], cols[c], 32'h0, 4'h0);
      chk(ref_cnt > 0, "R9 refresh served during traffic", 64'(ref_cnt), 64'(1));
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule